// File: doc/BRIEF.md
# Add-with-carry execution unit

This unit carries out the add-with-carry instruction family of a small 8-bit accumulator processor. A one-cycle start strobe comes with an opcode byte. The unit decodes that byte and picks the operand from one of three places: a general register read through a register-file port, a byte in memory at the program counter, or a byte in memory at the address held in the H/L register pair. It adds the operand and the incoming carry flag to the accumulator. It then returns the wrapped 8-bit sum and a new flag byte through a write port.

Register forms finish in the cycle of the strobe. The two memory forms issue one read on a synchronous read port in the strobe cycle and commit in the following cycle. The immediate form also writes back the program counter advanced by one. The core around the unit holds the registers, the flags and the program counter and applies the writes at the clock edge. A strobe that carries an opcode outside the family does nothing.

Top module: `adc_exec_unit`

## Requirements
- R1: On commit, `acc_wdata` equals (accumulator + operand + carry-in) modulo 256, where carry-in is bit 4 of `flag_in`.
- R2: On commit, bit 6 (subtract) of `flag_wdata` is 0 and bits 3..0 are 0.
- R3: On commit, bit 7 (zero) of `flag_wdata` is 1 exactly when `acc_wdata` is 0x00.
- R4: On commit, bit 4 (carry) of `flag_wdata` is the carry out of bit 7 of the full sum.
- R5: On commit, bit 5 (half-carry) of `flag_wdata` is 1 when the low nibble of the accumulator, plus the low nibble of the operand, plus carry-in, exceeds 0xF.
- R6: Opcodes 0x88–0x8D and 0x8F drive `rf_rd_sel` with opcode bits 2..0 (B=0, C=1, D=2, E=3, H=4, L=5, A=7). They raise `done` and `acc_we` in the strobe cycle and issue no memory read.
- R7: Opcode 0xCE raises `mem_rd_en` with `mem_addr` = `pc_in` in the strobe cycle. It commits the next cycle with `pc_we` = 1 and `pc_wdata` = `pc_in` + 1, wrapping 0xFFFF to 0x0000.
- R8: Opcode 0x8E raises `mem_rd_en` with `mem_addr` = `hl_in` (H upper byte, L lower byte) in the strobe cycle. It commits the next cycle with `pc_we` = 0.
- R9: A strobe with any other opcode raises no `done`, `acc_we`, `pc_we` or `mem_rd_en`.
- R10: A strobe in the commit cycle of a two-cycle form is ignored. `done` is 1 only in cycles where `acc_we` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle instruction strobe |
| opcode | input | 8 | Opcode byte, valid with `start` |
| acc_in | input | 8 | Current accumulator |
| flag_in | input | 8 | Current flag byte (carry in bit 4) |
| hl_in | input | 16 | H/L pair, H in the upper byte |
| pc_in | input | 16 | Current program counter |
| rf_rd_sel | output | 3 | Register-file read index |
| rf_rd_data | input | 8 | Register-file read data (combinational) |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Memory data, valid the cycle after the request |
| acc_we | output | 1 | Accumulator and flag write enable |
| acc_wdata | output | 8 | New accumulator |
| flag_wdata | output | 8 | New flag byte |
| pc_we | output | 1 | Program-counter write enable |
| pc_wdata | output | 16 | New program counter |
| done | output | 1 | Instruction complete, high in the commit cycle |

## Verification
The only internal state is the pending-commit phase and the operand source held with it. If either is wrong, the fault shows at the ports in the cycle after the strobe: a missing or doubled `done`, a commit that reads register data instead of memory data, or a `pc_we` on the indirect form. Faults in the arithmetic and flag logic are combinational and appear in `acc_wdata` or `flag_wdata` in the commit cycle itself. The boundary sums 0xFF+0x00+1 and 0x0F+0x00+1 and a program counter at 0xFFFF expose them directly.

// File: rtl/adc_pkg.sv
// Package: shared encodings for the add-with-carry unit.
// Assumes an 8-bit flag byte with Z/N/H/C in bits 7..4.
package adc_pkg;

    localparam int FLAG_Z = 7;
    localparam int FLAG_N = 6;
    localparam int FLAG_H = 5;
    localparam int FLAG_C = 4;

    localparam logic [7:0] OP_IMM = 8'hCE;
    localparam logic [7:0] OP_IND = 8'h8E;
    localparam logic [4:0] OP_REG_HI = 5'b10001;
    localparam logic [2:0] REG_SEL_HOLE = 3'b110;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_REG,
        SRC_IMM,
        SRC_IND
    } src_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

endpackage

// File: rtl/adc_decode.sv
// Opcode decoder: classifies the opcode byte into an operand source and
// gives the register index. Purely combinational; assumes opcode is valid
// whenever it is used.
module adc_decode
    import adc_pkg::*;
(
    input  logic [7:0] opcode,
    output src_e       src,
    output logic [2:0] reg_sel
);

    // Classify the opcode; the register index is the low three bits.
    always_comb begin
        reg_sel = opcode[2:0];
        if (opcode[7:3] == OP_REG_HI && opcode[2:0] != REG_SEL_HOLE) begin
            src = SRC_REG;
        end else if (opcode == OP_IND) begin
            src = SRC_IND;
        end else if (opcode == OP_IMM) begin
            src = SRC_IMM;
        end else begin
            src = SRC_NONE;
        end
    end

endmodule

// File: rtl/adc_alu.sv
// Adder with flag generation: sum = a + b + cin, wrapped to DW bits.
// Half-carry is taken from the low nibble including cin. Assumes DW >= 8.
module adc_alu
    import adc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output flags_t        fl
);

    localparam int NW = 4;

    logic [DW:0] full;
    logic [NW:0] low;

    // Full-width and nibble-width sums, each with the carry-in.
    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        low  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        sum  = full[DW-1:0];
        fl.z = (full[DW-1:0] == '0);
        fl.n = 1'b0;
        fl.h = low[NW];
        fl.c = full[DW];
    end

endmodule

// File: rtl/adc_seq.sv
// Sequencer: accepts a strobe when idle, and for memory forms holds a
// one-cycle commit phase with the operand source. Synchronous active-low reset.
module adc_seq
    import adc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  src_e src,
    output logic accept,
    output logic phase2_q,
    output src_e held_src_q
);

    // A strobe is taken only outside the commit phase and for a known opcode.
    always_comb begin
        accept = start && !phase2_q && (src != SRC_NONE);
    end

    // Enter the commit phase after a memory-form strobe; leave it after one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase2_q   <= 1'b0;
            held_src_q <= SRC_NONE;
        end else if (accept && (src == SRC_IMM || src == SRC_IND)) begin
            phase2_q   <= 1'b1;
            held_src_q <= src;
        end else if (phase2_q) begin
            phase2_q   <= 1'b0;
            held_src_q <= SRC_NONE;
        end
    end

endmodule

// File: rtl/adc_exec_unit.sv
// Add-with-carry execution unit. Register forms commit in the strobe cycle;
// memory forms read in the strobe cycle and commit in the next one. Assumes
// the caller holds acc_in/flag_in/pc_in/hl_in stable until commit and applies
// the write ports at the clock edge.
module adc_exec_unit
    import adc_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] flag_in,
    input  logic [AW-1:0] hl_in,
    input  logic [AW-1:0] pc_in,
    output logic [2:0]    rf_rd_sel,
    input  logic [DW-1:0] rf_rd_data,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rd_data,
    output logic          acc_we,
    output logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] flag_wdata,
    output logic          pc_we,
    output logic [AW-1:0] pc_wdata,
    output logic          done
);

    src_e          src;
    src_e          held_src_q;
    logic          accept;
    logic          phase2_q;
    logic          commit;
    logic [DW-1:0] operand;
    logic [DW-1:0] sum;
    flags_t        fl;

    adc_decode u_decode (
        .opcode  (opcode),
        .src     (src),
        .reg_sel (rf_rd_sel)
    );

    adc_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .src        (src),
        .accept     (accept),
        .phase2_q   (phase2_q),
        .held_src_q (held_src_q)
    );

    adc_alu #(.DW(DW)) u_alu (
        .a   (acc_in),
        .b   (operand),
        .cin (flag_in[FLAG_C]),
        .sum (sum),
        .fl  (fl)
    );

    // Memory request and operand selection.
    always_comb begin
        mem_rd_en = accept && (src == SRC_IMM || src == SRC_IND);
        mem_addr  = (src == SRC_IND) ? hl_in : pc_in;
        operand   = phase2_q ? mem_rd_data : rf_rd_data;
    end

    // Commit strobes and write data.
    always_comb begin
        commit             = (accept && src == SRC_REG) || phase2_q;
        acc_we             = commit;
        done               = commit;
        acc_wdata          = sum;
        flag_wdata         = '0;
        flag_wdata[FLAG_Z] = fl.z;
        flag_wdata[FLAG_N] = fl.n;
        flag_wdata[FLAG_H] = fl.h;
        flag_wdata[FLAG_C] = fl.c;
        pc_we              = phase2_q && (held_src_q == SRC_IMM);
        pc_wdata           = pc_in + AW'(1);
    end

endmodule

// File: rtl/adc_exec_checker.sv
// Checker for adc_exec_unit: port-level timing and flag-format properties.
// Attached to every instance of the top by the bind below.
module adc_exec_checker
    import adc_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [7:0]    opcode,
    input logic [AW-1:0] hl_in,
    input logic [AW-1:0] pc_in,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_addr,
    input logic          acc_we,
    input logic [DW-1:0] acc_wdata,
    input logic [DW-1:0] flag_wdata,
    input logic          pc_we,
    input logic [AW-1:0] pc_wdata,
    input logic          done,
    input logic          phase2_q
);

    logic is_reg_op;
    logic is_imm_op;
    logic is_ind_op;
    logic take;

    always_comb begin
        is_reg_op = (opcode[7:3] == OP_REG_HI) && (opcode[2:0] != REG_SEL_HOLE);
        is_imm_op = (opcode == OP_IMM);
        is_ind_op = (opcode == OP_IND);
        take      = start && !phase2_q;
    end

    assert_flag_format_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |-> (!flag_wdata[FLAG_N] && flag_wdata[3:0] == 4'h0));

    assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |-> (flag_wdata[FLAG_Z] == (acc_wdata == '0)));

    assert_reg_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_reg_op) |-> (done && acc_we && !mem_rd_en));

    assert_imm_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_imm_op) |-> (mem_rd_en && mem_addr == pc_in && !done));

    assert_imm_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_imm_op) |=> (done && pc_we && pc_wdata == $past(pc_in) + AW'(1)));

    assert_ind_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_ind_op) |-> (mem_rd_en && mem_addr == hl_in && !done));

    assert_ind_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_ind_op) |=> (done && !pc_we));

    assert_ignore_other_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !is_reg_op && !is_imm_op && !is_ind_op) |-> (!done && !acc_we && !pc_we && !mem_rd_en));

    assert_no_read_in_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        phase2_q |-> !mem_rd_en);

    assert_done_with_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> acc_we);

endmodule

bind adc_exec_unit adc_exec_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .opcode     (opcode),
    .hl_in      (hl_in),
    .pc_in      (pc_in),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .acc_we     (acc_we),
    .acc_wdata  (acc_wdata),
    .flag_wdata (flag_wdata),
    .pc_we      (pc_we),
    .pc_wdata   (pc_wdata),
    .done       (done),
    .phase2_q   (phase2_q)
);

// File: tb/adc_exec_unit_tb.sv
`timescale 1ns/1ps
module adc_exec_unit_tb;

    typedef struct {
        logic [7:0]  acc;
        logic [7:0]  f;
        logic        pcwe;
        logic [15:0] pc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  regs [8];
    logic [7:0]  fr;
    logic [15:0] pc;
    logic [7:0]  acc_in, flag_in, rf_rd_data, mem_rd_data;
    logic [15:0] hl_in, pc_in, mem_addr, pc_wdata;
    logic [2:0]  rf_rd_sel;
    logic        mem_rd_en, acc_we, pc_we, done;
    logic [7:0]  acc_wdata, flag_wdata;
    logic [7:0]  mem [logic [15:0]];

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail = 0;

    logic        cap_we, cap_pcwe;
    logic [7:0]  cap_acc, cap_f;
    logic [15:0] cap_pc;

    always #2 clk = ~clk;

    assign acc_in     = regs[7];
    assign flag_in    = fr;
    assign hl_in      = {regs[4], regs[5]};
    assign pc_in      = pc;
    assign rf_rd_data = regs[rf_rd_sel];

    adc_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .acc_in(acc_in), .flag_in(flag_in), .hl_in(hl_in), .pc_in(pc_in),
        .rf_rd_sel(rf_rd_sel), .rf_rd_data(rf_rd_data),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .acc_we(acc_we), .acc_wdata(acc_wdata), .flag_wdata(flag_wdata),
        .pc_we(pc_we), .pc_wdata(pc_wdata), .done(done)
    );

    function automatic logic [7:0] mem_get(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    // Synchronous memory read port
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem_get(mem_addr);
    end

    function automatic void ref_add(input logic [7:0] a, input logic [7:0] b, input logic c,
                                    output logic [7:0] res, output logic [7:0] f);
        logic [8:0] s;
        logic [4:0] lo;
        s   = {1'b0, a} + {1'b0, b} + {8'h00, c};
        lo  = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'h0, c};
        res = s[7:0];
        f   = {(s[7:0] == 8'h00), 1'b0, lo[4], s[8], 4'h0};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_reg(input logic [7:0] op);
        return (op[7:3] == 5'b10001) && (op[2:0] != 3'b110);
    endfunction

    task automatic capture();
        cap_we   = done && acc_we;
        cap_acc  = acc_wdata;
        cap_f    = flag_wdata;
        cap_pcwe = done && pc_we;
        cap_pc   = pc_wdata;
    endtask

    task automatic apply();
        if (cap_we) begin
            regs[7] = cap_acc;
            fr      = cap_f;
        end
        if (cap_pcwe) pc = cap_pc;
        cap_we   = 1'b0;
        cap_pcwe = 1'b0;
    endtask

    function automatic exp_t predict(input logic [7:0] op);
        exp_t       e;
        logic [7:0] operand;
        if (is_reg(op)) begin
            operand = regs[op[2:0]];
            e.tag   = "R6";
        end else if (op == 8'hCE) begin
            operand = mem_get(pc);
            e.tag   = "R7";
        end else begin
            operand = mem_get({regs[4], regs[5]});
            e.tag   = "R8";
        end
        ref_add(regs[7], operand, fr[4], e.acc, e.f);
        e.pcwe = (op == 8'hCE);
        e.pc   = pc + 16'd1;
        return e;
    endfunction

    // Driver: pushes the expected item, then runs the strobe and commit cycles.
    task automatic issue(input logic [7:0] op);
        exp_t e;
        e = predict(op);
        q.push_back(e);
        start  = 1'b1;
        opcode = op;
        @(negedge clk);
        if (op == 8'hCE) begin
            check("R7 read request", {15'd0, mem_rd_en}, 16'd1);
            check("R7 read address", mem_addr, pc);
        end else if (op == 8'h8E) begin
            check("R8 read request", {15'd0, mem_rd_en}, 16'd1);
            check("R8 read address", mem_addr, {regs[4], regs[5]});
        end
        capture();
        @(posedge clk); #1;
        start = 1'b0;
        if (!is_reg(op)) begin
            @(negedge clk);
            capture();
            @(posedge clk); #1;
        end
        apply();
    endtask

    task automatic issue_bad(input logic [7:0] op);
        logic [7:0] a0;
        a0     = regs[7];
        start  = 1'b1;
        opcode = op;
        @(negedge clk);
        check("R9 done", {15'd0, done}, 16'd0);
        check("R9 acc_we", {15'd0, acc_we}, 16'd0);
        check("R9 mem_rd_en", {15'd0, mem_rd_en}, 16'd0);
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        check("R9 no late done", {15'd0, done}, 16'd0);
        check("R9 accumulator kept", {8'd0, regs[7]}, {8'd0, a0});
        @(posedge clk); #1;
    endtask

    task automatic monitor();
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (q.size() == 0) begin
                    n_tests++;
                    n_fail++;
                    $display("FAIL R10 unexpected done actual=1 expected=0");
                end else begin
                    e = q.pop_front();
                    check({e.tag, " R1 sum"}, {8'd0, acc_wdata}, {8'd0, e.acc});
                    check({e.tag, " R2/R3/R4/R5 flags"}, {8'd0, flag_wdata}, {8'd0, e.f});
                    check({e.tag, " R7/R8 pc_we"}, {15'd0, pc_we}, {15'd0, e.pcwe});
                    if (e.pcwe) check({e.tag, " R7 pc_wdata"}, pc_wdata, e.pc);
                    check({e.tag, " R6 no read at commit"}, {15'd0, mem_rd_en}, 16'd0);
                end
            end
        end
    endtask

    task automatic randomize_state();
        for (int i = 0; i < 8; i++) regs[i] = 8'($urandom);
        regs[6] = 8'h00;
        fr      = {4'($urandom), 4'h0};
        pc      = 16'($urandom);
        mem[pc] = 8'($urandom);
        mem[{regs[4], regs[5]}] = 8'($urandom);
    endtask

    task automatic run_tests();
        logic [7:0] ops [9];
        ops = '{8'h88, 8'h89, 8'h8A, 8'h8B, 8'h8C, 8'h8D, 8'h8F, 8'hCE, 8'h8E};

        // Reset state
        @(negedge clk);
        check("R10 reset done", {15'd0, done}, 16'd0);
        check("R10 reset acc_we", {15'd0, acc_we}, 16'd0);
        check("R10 reset mem_rd_en", {15'd0, mem_rd_en}, 16'd0);
        check("R10 reset pc_we", {15'd0, pc_we}, 16'd0);
        @(posedge clk); #1;

        // R6: every register opcode, carry-in 0 and 1
        for (int k = 0; k < 7; k++) begin
            for (int c = 0; c < 2; c++) begin
                randomize_state();
                fr[4] = 1'(c);
                issue(ops[k]);
            end
        end

        // R5/R4/R3: 0xFF + 0x00 + 1
        regs[7] = 8'hFF; regs[0] = 8'h00; fr = 8'h10;
        issue(8'h88);
        check("R1 wrap sum", {8'd0, regs[7]}, 16'h0000);
        check("R3/R4/R5 wrap flags", {8'd0, fr}, 16'h00B0);

        // R5: 0x0F + 0x00 + 1
        regs[7] = 8'h0F; regs[0] = 8'h00; fr = 8'h10;
        issue(8'h88);
        check("R5 nibble sum", {8'd0, regs[7]}, 16'h0010);
        check("R5 nibble flags", {8'd0, fr}, 16'h0020);

        // R7: program counter wraps
        regs[7] = 8'h10; fr = 8'h00; pc = 16'hFFFF; mem[16'hFFFF] = 8'h01;
        issue(8'hCE);
        check("R7 imm sum", {8'd0, regs[7]}, 16'h0011);
        check("R7 pc wrap", pc, 16'h0000);

        // R8: indirect through H/L
        regs[7] = 8'h80; regs[4] = 8'h12; regs[5] = 8'h34; fr = 8'h00; pc = 16'h0100;
        mem[16'h1234] = 8'h80;
        issue(8'h8E);
        check("R8 ind sum", {8'd0, regs[7]}, 16'h0000);
        check("R8 ind flags", {8'd0, fr}, 16'h0090);
        check("R8 pc kept", pc, 16'h0100);

        // R9: opcodes outside the family
        issue_bad(8'h00);
        issue_bad(8'h80);
        issue_bad(8'h86);
        issue_bad(8'h87);
        issue_bad(8'h98);
        issue_bad(8'hCF);
        issue_bad(8'hFF);

        // R10: strobe during the commit cycle is ignored
        randomize_state();
        begin
            exp_t e;
            e = predict(8'hCE);
            q.push_back(e);
            start = 1'b1; opcode = 8'hCE;
            @(posedge clk); #1;
            opcode = 8'h88;
            @(negedge clk);
            check("R10 no read in commit", {15'd0, mem_rd_en}, 16'd0);
            capture();
            @(posedge clk); #1;
            start = 1'b0;
            apply();
            @(negedge clk);
            check("R10 strobe ignored", {15'd0, done}, 16'd0);
            @(posedge clk); #1;
        end

        // R1: random mix of all forms
        for (int n = 0; n < 300; n++) begin
            randomize_state();
            issue(ops[$urandom_range(0, 8)]);
        end

        @(negedge clk);
        check("R10 scoreboard drained", 16'(q.size()), 16'd0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = 8'h00;
        fr = 8'h00;
        pc = 16'h0000;
        cap_we = 1'b0;
        cap_pcwe = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        fork
            monitor();
        join_none
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL R1 watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule